// File: doc/BRIEF.md
# PUF self-test and repair controller

This block screens an array of multimode SRAM PUF cells once, on chip, and builds a per-bit repair and validity map without an external tester. Each cell can be read in three ways. Two readouts give the cell's two key bits, and the third is held back as a spare. For each key bit the controller runs a stability screen. It reads the bit unbiased, then with a positive bias tilt, then with a negative bias tilt. The bit counts as stable only when both tilted reads agree with the unbiased read.

A key bit that fails the screen is moved to the cell's spare readout, and the spare goes through the same three-read screen before it is accepted. The spare can stand in for at most one key bit per cell. When a bit cannot be repaired it is marked as discarded, so the key assembly logic can leave it out. Every read drives the cell address, readout select and bias lines, then waits a programmable number of settle cycles before it samples the response. A one-cycle done pulse ends the scan. The resulting map can be read at any time through a small address port.

Top module: `puf_selfrepair`

## Requirements
- R1: `modeSel` uses 00 for the first key readout, 01 for the second and 10 for the spare, and never shows 11. Each screen issues three reads in the order unbiased, positive tilt (`biasPos`=1), negative tilt (`biasNeg`=1). The two bias lines are never high together.
- R2: Once `cellAddr`/`modeSel`/bias change, they are held for at least `settleCycles`+1 cycles. The response is sampled in the last of those cycles, so a response that settles only `settleCycles` cycles after the change is captured correctly.
- R3: A key bit whose positive and negative reads both equal its unbiased read gets status 00 (good), and no spare reads follow it.
- R4: A key bit that fails, while its cell's spare is still free, is followed directly by the three spare reads (`modeSel`=10). If the spare passes, the bit's status is 01 (repaired) and the spare is then taken.
- R5: A key bit whose spare screen also fails gets status 10 (discarded). The spare stays free for the cell's second key bit, which is screened on the spare again if it fails.
- R6: If the first key bit of a cell was repaired and the second key bit fails, the second bit gets status 10 without any spare read.
- R7: Cells are visited in ascending address order from 0. Within a cell, key bit 0 (with its spare screen, if any) comes before key bit 1.
- R8: `done` is high for exactly one cycle after the last bit of the last cell is decided. A `start` pulse during a scan is ignored and does not restart it.
- R9: After reset all outputs are 0 and every map entry reads 00.
- R10: `mapStatus` returns the 2-bit status of key bit `mapSel` of cell `mapCell` (00 good, 01 repaired, 10 discarded, 11 never used).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a scan when idle |
| settleCycles | input | SETTLE_W | Extra cycles each read waits before sampling |
| respIn | input | 1 | Response bit from the addressed cell |
| mapCell | input | ADDR_W | Map read: cell index |
| mapSel | input | 1 | Map read: key bit 0 or 1 |
| done | output | 1 | One-cycle end-of-scan pulse |
| cellAddr | output | ADDR_W | Cell under test |
| modeSel | output | 2 | Readout select |
| biasPos | output | 1 | Positive bias tilt enable |
| biasNeg | output | 1 | Negative bias tilt enable |
| mapStatus | output | 2 | Status of the selected map entry |

## Verification
The bench's cell model returns a wrong bit until the configured settle time has passed. A controller that samples one cycle early therefore sees false instability, and both its read sequence and its map come out wrong. Cells are arranged so that every repair path occurs: failure on either key bit, a spare that passes, a spare that fails and is then retried for the second bit, and a spare already taken. A design that skips the spare screen, reuses a taken spare, or tests spare reads for a bit it should simply discard shows up as a mismatch in the expected read sequence. Settle values of zero and larger values are both used, and a stray start pulse mid-scan exposes a controller that restarts.

// File: rtl/puf_repair_pkg.sv
package puf_repair_pkg;

  typedef enum logic [1:0] {
    STAT_GOOD  = 2'b00,
    STAT_FIXED = 2'b01,
    STAT_DROP  = 2'b10
  } bitStat_e;

  localparam logic [1:0] SEL_SPARE = 2'b10;

  typedef struct packed {
    logic     launch;
    logic     capture;
    logic     trySpare;
    logic     record;
    bitStat_e recVal;
    logic     advance;
  } ctlStrobe_t;

  typedef struct packed {
    logic settled;
    logic lastRead;
    logic stable;
    logic onSpare;
    logic spareTaken;
    logic secondBit;
    logic finalBit;
  } pathFlag_t;

endpackage

// File: rtl/puf_repair_path.sv
module puf_repair_path
  import puf_repair_pkg::*;
#(
  parameter int N_CELLS  = 16,
  parameter int SETTLE_W = 4,
  localparam int ADDR_W  = (N_CELLS > 1) ? $clog2(N_CELLS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          ctl,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic                respIn,
  input  logic [ADDR_W-1:0]   mapCell,
  input  logic                mapSel,
  output pathFlag_t           flags,
  output logic [ADDR_W-1:0]   cellAddr,
  output logic [1:0]          modeSel,
  output logic                biasPos,
  output logic                biasNeg,
  output logic [1:0]          mapStatus
);

  localparam int MAP_N = 2 * N_CELLS;
  localparam int IDX_W = ADDR_W + 1;
  localparam logic [ADDR_W-1:0] LAST_CELL = ADDR_W'(N_CELLS - 1);

  logic [ADDR_W-1:0]   cellQ;
  logic                bitQ;
  logic                spareQ;
  logic                takenQ;
  logic [1:0]          stepQ;
  logic [SETTLE_W-1:0] waitQ;
  logic                refQ, posQ, negQ;
  logic [1:0]          statMap [MAP_N];
  logic [IDX_W-1:0]    wrIdx;
  logic                reload;

  assign reload = ctl.launch | ctl.trySpare | ctl.advance |
                  (ctl.capture && stepQ != 2'd2);
  assign wrIdx  = {cellQ, bitQ};

  // Position in the scan: cell, key bit, spare flag, tilt step
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cellQ  <= '0;
      bitQ   <= 1'b0;
      spareQ <= 1'b0;
      takenQ <= 1'b0;
      stepQ  <= 2'd0;
    end else if (ctl.launch) begin
      cellQ  <= '0;
      bitQ   <= 1'b0;
      spareQ <= 1'b0;
      takenQ <= 1'b0;
      stepQ  <= 2'd0;
    end else begin
      if (ctl.capture && stepQ != 2'd2) stepQ <= stepQ + 2'd1;
      if (ctl.trySpare) begin
        spareQ <= 1'b1;
        stepQ  <= 2'd0;
      end
      if (ctl.record && ctl.recVal == STAT_FIXED) takenQ <= 1'b1;
      if (ctl.advance) begin
        spareQ <= 1'b0;
        stepQ  <= 2'd0;
        if (bitQ) begin
          bitQ   <= 1'b0;
          takenQ <= 1'b0;
          cellQ  <= (cellQ == LAST_CELL) ? '0 : cellQ + ADDR_W'(1);
        end else begin
          bitQ <= 1'b1;
        end
      end
    end
  end

  // Settle counter restarts whenever the drive changes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               waitQ <= '0;
    else if (reload)         waitQ <= settleCycles;
    else if (waitQ != '0)    waitQ <= waitQ - SETTLE_W'(1);
  end

  // Three response samples of the current screen
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refQ <= 1'b0;
      posQ <= 1'b0;
      negQ <= 1'b0;
    end else if (ctl.capture) begin
      unique case (stepQ)
        2'd0:    refQ <= respIn;
        2'd1:    posQ <= respIn;
        default: negQ <= respIn;
      endcase
    end
  end

  // Repair map, one 2-bit entry per key bit
  for (genvar e = 0; e < MAP_N; e++) begin : g_map
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                    statMap[e] <= STAT_GOOD;
      else if (ctl.record && wrIdx == IDX_W'(e))    statMap[e] <= ctl.recVal;
    end
  end

  always_comb begin
    if (mapCell <= LAST_CELL) mapStatus = statMap[{mapCell, mapSel}];
    else                      mapStatus = STAT_GOOD;
  end

  assign cellAddr = cellQ;
  assign modeSel  = spareQ ? SEL_SPARE : {1'b0, bitQ};
  assign biasPos  = (stepQ == 2'd1);
  assign biasNeg  = (stepQ == 2'd2);

  assign flags.settled    = (waitQ == '0);
  assign flags.lastRead   = (stepQ == 2'd2);
  assign flags.stable     = (posQ == refQ) && (negQ == refQ);
  assign flags.onSpare    = spareQ;
  assign flags.spareTaken = takenQ;
  assign flags.secondBit  = bitQ;
  assign flags.finalBit   = bitQ && (cellQ == LAST_CELL);

endmodule

// File: rtl/puf_repair_ctrl.sv
module puf_repair_ctrl
  import puf_repair_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  pathFlag_t  flags,
  output ctlStrobe_t ctl,
  output logic       done
);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_JUDGE, S_FINISH} state_e;

  state_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    ctl    = '0;
    stateD = stateQ;
    unique case (stateQ)
      S_IDLE: begin
        if (start) begin
          ctl.launch = 1'b1;
          stateD     = S_READ;
        end
      end
      S_READ: begin
        if (flags.settled) begin
          ctl.capture = 1'b1;
          if (flags.lastRead) stateD = S_JUDGE;
        end
      end
      S_JUDGE: begin
        if (!flags.onSpare && flags.stable) begin
          ctl.record  = 1'b1;
          ctl.recVal  = STAT_GOOD;
          ctl.advance = 1'b1;
        end else if (!flags.onSpare && flags.secondBit && flags.spareTaken) begin
          ctl.record  = 1'b1;
          ctl.recVal  = STAT_DROP;
          ctl.advance = 1'b1;
        end else if (!flags.onSpare) begin
          ctl.trySpare = 1'b1;
          stateD       = S_READ;
        end else begin
          ctl.record  = 1'b1;
          ctl.recVal  = flags.stable ? STAT_FIXED : STAT_DROP;
          ctl.advance = 1'b1;
        end
        if (ctl.advance) stateD = flags.finalBit ? S_FINISH : S_READ;
      end
      default: stateD = S_IDLE;
    endcase
  end

  assign done = (stateQ == S_FINISH);

endmodule

// File: rtl/puf_selfrepair.sv
module puf_selfrepair
  import puf_repair_pkg::*;
#(
  parameter int N_CELLS  = 16,
  parameter int SETTLE_W = 4,
  localparam int ADDR_W  = (N_CELLS > 1) ? $clog2(N_CELLS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic                respIn,
  input  logic [ADDR_W-1:0]   mapCell,
  input  logic                mapSel,
  output logic                done,
  output logic [ADDR_W-1:0]   cellAddr,
  output logic [1:0]          modeSel,
  output logic                biasPos,
  output logic                biasNeg,
  output logic [1:0]          mapStatus
);

  ctlStrobe_t ctl;
  pathFlag_t  flags;

  puf_repair_ctrl i_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .flags (flags),
    .ctl   (ctl),
    .done  (done)
  );

  puf_repair_path #(
    .N_CELLS  (N_CELLS),
    .SETTLE_W (SETTLE_W)
  ) i_path (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .settleCycles (settleCycles),
    .respIn       (respIn),
    .mapCell      (mapCell),
    .mapSel       (mapSel),
    .flags        (flags),
    .cellAddr     (cellAddr),
    .modeSel      (modeSel),
    .biasPos      (biasPos),
    .biasNeg      (biasNeg),
    .mapStatus    (mapStatus)
  );

endmodule

// File: rtl/puf_selfrepair_chk.sv
module puf_selfrepair_chk #(
  parameter int N_CELLS  = 16,
  parameter int SETTLE_W = 4,
  localparam int ADDR_W  = (N_CELLS > 1) ? $clog2(N_CELLS) : 1
) (
  input logic                clk,
  input logic                rstN,
  input logic                done,
  input logic [ADDR_W-1:0]   cellAddr,
  input logic [1:0]          modeSel,
  input logic                biasPos,
  input logic                biasNeg,
  input logic [SETTLE_W-1:0] settleCycles,
  input logic [1:0]          mapStatus
);

  localparam int DRV_W = ADDR_W + 4;

  logic [DRV_W-1:0]  drvNow, drvQ;
  logic [SETTLE_W:0] holdCnt;
  logic              moved;

  assign drvNow = {cellAddr, modeSel, biasPos, biasNeg};
  assign moved  = (drvNow != drvQ);

  // Counts how many cycles the previous drive value stayed put
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drvQ    <= '0;
      holdCnt <= '0;
    end else begin
      drvQ <= drvNow;
      if (moved)              holdCnt <= (SETTLE_W+1)'(1);
      else if (holdCnt != '1) holdCnt <= holdCnt + (SETTLE_W+1)'(1);
    end
  end

  AST_BIAS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({biasPos, biasNeg})); // R1

  AST_MODE_CODE: assert property (@(posedge clk) disable iff (!rstN)
    modeSel != 2'b11); // R1

  AST_TILT_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(biasNeg) |-> $past(biasPos)); // R1

  AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    moved |-> (holdCnt >= ({1'b0, settleCycles} + (SETTLE_W+1)'(1)))); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_MAP_CODE: assert property (@(posedge clk) disable iff (!rstN)
    mapStatus != 2'b11); // R10

endmodule

bind puf_selfrepair puf_selfrepair_chk #(
  .N_CELLS  (N_CELLS),
  .SETTLE_W (SETTLE_W)
) i_chk (
  .clk          (clk),
  .rstN         (rstN),
  .done         (done),
  .cellAddr     (cellAddr),
  .modeSel      (modeSel),
  .biasPos      (biasPos),
  .biasNeg      (biasNeg),
  .settleCycles (settleCycles),
  .mapStatus    (mapStatus)
);

// File: tb/test_puf_selfrepair.sv
module test_puf_selfrepair;

  localparam int N_CELLS  = 8;
  localparam int SETTLE_W = 4;
  localparam int ADDR_W   = 3;
  localparam int DRV_W    = ADDR_W + 4;
  localparam int WD_LIMIT = 20000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                rstN, start, respIn, mapSel, done, biasPos, biasNeg;
  logic [SETTLE_W-1:0] settleCycles;
  logic [ADDR_W-1:0]   mapCell, cellAddr;
  logic [1:0]          modeSel, mapStatus;

  puf_selfrepair #(.N_CELLS(N_CELLS), .SETTLE_W(SETTLE_W)) i_puf_selfrepair (
    .clk(clk), .rstN(rstN), .start(start), .settleCycles(settleCycles),
    .respIn(respIn), .mapCell(mapCell), .mapSel(mapSel), .done(done),
    .cellAddr(cellAddr), .modeSel(modeSel), .biasPos(biasPos),
    .biasNeg(biasNeg), .mapStatus(mapStatus)
  );

  int checks = 0;
  int errors = 0;

  // ---------------- cell model: 0 stable, 1 flips under +tilt, 2 under -tilt
  int   kindOf [N_CELLS][3];
  logic baseOf [N_CELLS][3];
  int   age;
  logic [DRV_W-1:0] drvNow, drvPrev;
  logic trueR;
  int   mIdx;

  assign drvNow = {cellAddr, modeSel, biasPos, biasNeg};

  always @(negedge clk) begin
    if (!rstN) begin
      age     <= 1000;
      drvPrev <= drvNow;
    end else if (drvNow !== drvPrev) begin
      age     <= 0;
      drvPrev <= drvNow;
    end else if (age < 1000) begin
      age <= age + 1;
    end
  end

  always_comb begin
    mIdx   = (modeSel == 2'b11) ? 0 : int'(modeSel);
    trueR  = baseOf[cellAddr][mIdx] ^ (biasPos && kindOf[cellAddr][mIdx] == 1)
                                    ^ (biasNeg && kindOf[cellAddr][mIdx] == 2);
    respIn = (age >= int'(settleCycles)) ? trueR : ~baseOf[cellAddr][mIdx];
  end

  // ---------------- scoreboard
  logic [DRV_W-1:0] expQ[$];
  logic [1:0]       expMap [2*N_CELLS];
  string            expReq [2*N_CELLS];
  bit               monOn = 1'b0;
  bit               monFirst = 1'b0;
  logic [DRV_W-1:0] monPrev;
  int               monHold;
  int               runSettle;

  task automatic pushReads(input int c, input int m);
    expQ.push_back({ADDR_W'(c), 2'(m), 1'b0, 1'b0});
    expQ.push_back({ADDR_W'(c), 2'(m), 1'b1, 1'b0});
    expQ.push_back({ADDR_W'(c), 2'(m), 1'b0, 1'b1});
  endtask

  task automatic buildExpected();
    expQ.delete();
    for (int c = 0; c < N_CELLS; c++) begin
      bit taken = 1'b0;
      for (int b = 0; b < 2; b++) begin
        pushReads(c, b);
        if (kindOf[c][b] == 0) begin
          expMap[2*c+b] = 2'b00; expReq[2*c+b] = "R3";
        end else if (b == 1 && taken) begin
          expMap[2*c+b] = 2'b10; expReq[2*c+b] = "R6";
        end else begin
          pushReads(c, 2);
          if (kindOf[c][2] == 0) begin
            expMap[2*c+b] = 2'b01; expReq[2*c+b] = "R4";
            taken = 1'b1;
          end else begin
            expMap[2*c+b] = 2'b10; expReq[2*c+b] = "R5";
          end
        end
      end
    end
  endtask

  task automatic popCompare(input logic [DRV_W-1:0] got);
    logic [DRV_W-1:0] want;
    checks++;
    if (expQ.size() == 0) begin
      errors++;
      $display("FAIL R7: unexpected read drive %h, expected none", got);
    end else begin
      want = expQ.pop_front();
      if (got !== want) begin
        errors++;
        $display("FAIL R7/R1: read drive %h, expected %h", got, want);
      end
    end
  endtask

  // monitor: each new drive value is one read
  always @(negedge clk) begin
    if (monFirst) begin
      monFirst = 1'b0;
      monOn    = 1'b1;
      monPrev  = drvNow;
      monHold  = 1;
      popCompare(drvNow);
    end else if (monOn) begin
      if (done || drvNow !== monPrev) begin
        checks++;
        if (monHold < runSettle + 1) begin
          errors++;
          $display("FAIL R2: drive held %0d cycles, expected >= %0d", monHold, runSettle + 1);
        end
        if (done) monOn = 1'b0;
        else begin
          popCompare(drvNow);
          monPrev = drvNow;
          monHold = 1;
        end
      end else begin
        monHold++;
      end
    end
  end

  // ---------------- scenarios
  task automatic setStable();
    for (int c = 0; c < N_CELLS; c++)
      for (int m = 0; m < 3; m++) begin
        kindOf[c][m] = 0;
        baseOf[c][m] = 1'((c + m) % 2);
      end
  endtask

  task automatic setMixed(input int shift);
    for (int c = 0; c < N_CELLS; c++) begin
      int u = ((c % 8) < 4) ? 1 : 2;
      int k[3];
      case ((c + shift) % 4)
        0:       k = '{u, 0, 0};
        1:       k = '{0, u, 0};
        2:       k = '{u, u, u};
        default: k = '{u, u, 0};
      endcase
      for (int m = 0; m < 3; m++) begin
        kindOf[c][m] = k[m];
        baseOf[c][m] = 1'((c * 3 + m + shift) % 2);
      end
    end
  endtask

  task automatic runScan(input int settle, input bit poke);
    int cyc = 0;
    buildExpected();
    @(posedge clk); #2;
    settleCycles = SETTLE_W'(settle);
    runSettle    = settle;
    start        = 1'b1;
    @(posedge clk); #2;
    start    = 1'b0;
    monFirst = 1'b1;
    if (poke) begin
      repeat (9) @(posedge clk);
      #2 start = 1'b1;       // R8: must be ignored mid-scan
      @(posedge clk); #2 start = 1'b0;
    end
    while (!done && cyc < WD_LIMIT) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL R8: watchdog, done=%b expected 1", done);
      monOn = 1'b0;
      return;
    end
    @(negedge clk);
    checks++;
    if (done !== 1'b0) begin
      errors++;
      $display("FAIL R8: done=%b one cycle later, expected 0", done);
    end
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R7: %0d reads missing, expected 0", expQ.size());
    end
    repeat (4) begin
      @(negedge clk);
      checks++;
      if (done !== 1'b0) begin
        errors++;
        $display("FAIL R8: done=%b after scan, expected 0", done);
      end
    end
    for (int c = 0; c < N_CELLS; c++)
      for (int b = 0; b < 2; b++) begin
        mapCell = ADDR_W'(c);
        mapSel  = 1'(b);
        #1;
        checks++;
        if (mapStatus !== expMap[2*c+b]) begin
          errors++;
          $display("FAIL %s/R10: cell %0d bit %0d status %b, expected %b",
                   expReq[2*c+b], c, b, mapStatus, expMap[2*c+b]);
        end
      end
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; settleCycles = '0;
    mapCell = '0; mapSel = 1'b0; runSettle = 0;
    setStable();
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    // R9: reset state
    checks++;
    if ({done, cellAddr, modeSel, biasPos, biasNeg} !== '0) begin
      errors++;
      $display("FAIL R9: outputs %b, expected all zero",
               {done, cellAddr, modeSel, biasPos, biasNeg});
    end
    for (int e = 0; e < 2*N_CELLS; e++) begin
      mapCell = ADDR_W'(e / 2);
      mapSel  = 1'(e % 2);
      #1;
      checks++;
      if (mapStatus !== 2'b00) begin
        errors++;
        $display("FAIL R9: map entry %0d = %b, expected 00", e, mapStatus);
      end
    end

    runScan(2, 1'b0);   // R3: all stable
    setMixed(0);
    runScan(3, 1'b0);   // R4 R5 R6 R7
    runScan(0, 1'b1);   // R2 zero settle, R8 stray start
    setMixed(1);
    runScan(6, 1'b0);   // R2 long settle, rotated patterns

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule